// File: doc/BRIEF.md
# Eight-Channel Down-Counting Timer Unit

The block holds eight independent down-counters that share two prescaled tick streams, each derived from the peripheral clock by a power-of-two ratio. Software controls the unit through a single write port and a combinational read port. A unit-wide enable gates all counting. Each channel is started and stopped by write-one trigger bits, and a separate status register reports which channels are running. Every channel reloads from its own reload register and signals an event each time its count wraps.

Each channel drives one output pin, and the pin always shows that channel's output buffer bit. When a channel's output enable is clear, software owns the buffer bit. When it is set, hardware owns the bit in one of two ways. In toggle mode, the channel's own events invert it. In paired mode, the odd channel of a pair is set by its even neighbour's events and reset by its own events. A per-channel inversion bit shapes the paired set and reset values at the moment they are applied.

Address map (5-bit address): 0 unit enable (bit 0), 1 prescaler selects, 2 running status (read only), 3 start triggers, 4 stop triggers, 5 output enables, 6 output buffer, 7 inversion bits, 8 paired-mode bits, 9 tick-source bits, 16+n reload of channel n.

Top module: `timer_unit_top`

## Requirements
- R1: The unit enable (address 0, bit 0) resets to 0. While it is 0 no channel counts, no event occurs, and the prescaler phase is held at zero.
- R2: Address 1 holds tick select A in bits [3:0] and tick select B in bits [7:4]. Select value s gives one tick every 2^s peripheral clock cycles while the unit is enabled. Bit n of address 9 picks tick B (1) or tick A (0) for channel n.
- R3: Writing 1 to bit n of address 3 clears channel n's counter and sets status bit n (address 2) at the write edge. The first following tick loads the reload value R, so the first event falls on the (R+2)-th tick and each later event falls R+1 ticks after the previous one.
- R4: Writing 1 to bit n of address 4 clears status bit n at the write edge and halts channel n, which then produces no events.
- R5: Addresses 3 and 4 always read as 0. Writing 0 to a trigger bit leaves that channel's status and counting unchanged.
- R6: With output enable n = 1 (address 5) and paired-mode bit n = 0 (address 8), each event of channel n inverts pin n at the event edge.
- R7: With output enable and paired-mode bits both 1 on an odd channel n, an event of channel n-1 drives pin n to NOT inv[n], and an event of channel n drives it to inv[n]. When both events occur together, the reset (inv[n]) wins. An even channel in paired mode keeps its pin unchanged.
- R8: The inversion bits (address 7) have no immediate effect on a pin. They only shape the value written at paired set and reset moments.
- R9: While output enable n is 0, a write to address 6 drives pin n to the written bit on the next edge, and events leave it unchanged. While it is 1, software writes to that bit are ignored.
- R10: After reset, every register reads 0 and every pin is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 5 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| ch_out | output | 8 | Channel output pins |

## Verification
Register writes, triggers and buffer writes take effect at the clock edge that samples `wr_en`. The read port is combinational, so a read value is due in the same cycle as its address. A channel event changes a pin at the edge on which the deciding tick is sampled, which is the (R+2)-th tick after the start edge and every R+1 ticks after that. The bench drives inputs and samples outputs on the falling edge. Each directed check waits a known number of falling edges after the write edge. A cycle-level bench model, written in terms of tick counts since start rather than counter values, is compared with the pins and the status register on every cycle.

// File: rtl/timer_unit_pkg.sv
`timescale 1ns/1ps
package timer_unit_pkg;

  localparam int SEL_W = 4;
  localparam int PRE_W = 16;

  localparam int ADR_CTRL   = 0;
  localparam int ADR_PRESC  = 1;
  localparam int ADR_STATUS = 2;
  localparam int ADR_START  = 3;
  localparam int ADR_STOP   = 4;
  localparam int ADR_OEN    = 5;
  localparam int ADR_OBUF   = 6;
  localparam int ADR_LVL    = 7;
  localparam int ADR_MODE   = 8;
  localparam int ADR_CSEL   = 9;
  localparam int ADR_RELOAD = 16;

  // low 'sel' bits set: a tick fires when the phase counter has them all at 1
  function automatic logic [PRE_W-1:0] prescale_mask(input logic [SEL_W-1:0] sel);
    logic [PRE_W-1:0] m;
    for (int i = 0; i < PRE_W; i++) m[i] = (i < int'(sel));
    return m;
  endfunction

  // paired output: reset has priority over set, inversion applied only here
  function automatic logic pair_level(input logic cur, input logic set_ev,
                                      input logic rst_ev, input logic inv);
    if (rst_ev) return inv;
    if (set_ev) return ~inv;
    return cur;
  endfunction

endpackage

// File: rtl/timer_prescaler.sv
`timescale 1ns/1ps
module timer_prescaler
  import timer_unit_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_a_i,
  input  logic [SEL_W-1:0] sel_b_i,
  output logic             tick_a_o,
  output logic             tick_b_o
);
  localparam int NUM_TICK = 2;

  logic [PRE_W-1:0]                phase_q;
  logic [NUM_TICK-1:0][SEL_W-1:0]  sel;
  logic [NUM_TICK-1:0]             tick;

  assign sel[0]   = sel_a_i;
  assign sel[1]   = sel_b_i;
  assign tick_a_o = tick[0];
  assign tick_b_o = tick[1];

  always_ff @(posedge clk) begin
    if (!rst_n)     phase_q <= '0;
    else if (!en_i) phase_q <= '0;
    else            phase_q <= phase_q + 1'b1;
  end

  for (genvar g = 0; g < NUM_TICK; g++) begin : g_tick
    assign tick[g] = en_i && ((phase_q & prescale_mask(sel[g])) == prescale_mask(sel[g]));

    // a ratio above one never yields two ticks in a row
    assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick[g] && sel[g] != '0) |=> (!tick[g] || sel[g] != $past(sel[g])));
  end

  // the phase stays at zero while the unit is off
  assert_phase_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> phase_q == '0);

endmodule

// File: rtl/timer_channel.sv
`timescale 1ns/1ps
module timer_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             run_o,
  output logic             ev_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             primed_q;
  logic             step;
  logic             wrap;

  assign step  = run_q && tick_i && !start_i && !stop_i;
  assign wrap  = (cnt_q == '0);
  assign ev_o  = step && wrap && primed_q;
  assign run_o = run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      run_q    <= 1'b0;
      primed_q <= 1'b0;
    end else if (start_i) begin
      cnt_q    <= '0;
      run_q    <= 1'b1;
      primed_q <= 1'b0;
    end else if (stop_i) begin
      run_q    <= 1'b0;
    end else if (step) begin
      if (wrap) begin
        cnt_q    <= reload_i;
        primed_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assert_start_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (run_q && cnt_q == '0 && !primed_q));

  assert_event_reloads_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_o |=> cnt_q == $past(reload_i));

  assert_stop_halts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !start_i) |=> !run_q);

  assert_no_tick_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !start_i) |=> $stable(cnt_q));

endmodule

// File: rtl/timer_output_ctl.sv
`timescale 1ns/1ps
module timer_output_ctl
  import timer_unit_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] ev_i,
  input  logic [NUM_CH-1:0] oen_i,
  input  logic [NUM_CH-1:0] mode_i,
  input  logic [NUM_CH-1:0] lvl_i,
  input  logic              sw_we_i,
  input  logic [NUM_CH-1:0] sw_data_i,
  output logic [NUM_CH-1:0] pin_o
);
  logic [NUM_CH-1:0] buf_q;
  logic [NUM_CH-1:0] buf_d;

  assign pin_o = buf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) buf_q <= '0;
    else        buf_q <= buf_d;
  end

  for (genvar n = 0; n < NUM_CH; n++) begin : g_pin
    logic pair_set;
    if (n % 2 == 1) begin : g_slave
      assign pair_set = ev_i[n-1];
    end else begin : g_master
      assign pair_set = 1'b0;
    end

    always_comb begin
      buf_d[n] = buf_q[n];
      if (!oen_i[n]) begin
        if (sw_we_i) buf_d[n] = sw_data_i[n];
      end else if (!mode_i[n]) begin
        if (ev_i[n]) buf_d[n] = ~buf_q[n];
      end else if (n % 2 == 1) begin
        buf_d[n] = pair_level(buf_q[n], pair_set, ev_i[n], lvl_i[n]);
      end
    end

    assert_toggle_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (oen_i[n] && !mode_i[n] && ev_i[n]) |=> buf_q[n] != $past(buf_q[n]));

    assert_sw_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!oen_i[n] && !sw_we_i) |=> $stable(buf_q[n]));

    if (n % 2 == 1) begin : g_pair_chk
      assert_pair_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (oen_i[n] && mode_i[n] && ev_i[n]) |=> buf_q[n] == $past(lvl_i[n]));
    end else begin : g_master_chk
      assert_master_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (oen_i[n] && mode_i[n]) |=> $stable(buf_q[n]));
    end
  end

endmodule

// File: rtl/timer_unit_top.sv
`timescale 1ns/1ps
module timer_unit_top
  import timer_unit_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [NUM_CH-1:0] ch_out
);
  localparam int PAD_CH = DATA_W - NUM_CH;

  logic              unit_en_q;
  logic [SEL_W-1:0]  sel_a_q;
  logic [SEL_W-1:0]  sel_b_q;
  logic [NUM_CH-1:0] csel_q;
  logic [NUM_CH-1:0] oen_q;
  logic [NUM_CH-1:0] lvl_q;
  logic [NUM_CH-1:0] mode_q;
  logic [CNT_W-1:0]  reload_q [NUM_CH];

  logic [NUM_CH-1:0] start_vec;
  logic [NUM_CH-1:0] stop_vec;
  logic [NUM_CH-1:0] run_vec;
  logic [NUM_CH-1:0] ev_vec;
  logic              tick_a;
  logic              tick_b;
  logic              obuf_we;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int target);
    return a == ADDR_W'(target);
  endfunction

  assign start_vec = (wr_en && hit(wr_addr, ADR_START)) ? wr_data[NUM_CH-1:0] : '0;
  assign stop_vec  = (wr_en && hit(wr_addr, ADR_STOP))  ? wr_data[NUM_CH-1:0] : '0;
  assign obuf_we   = wr_en && hit(wr_addr, ADR_OBUF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      unit_en_q <= 1'b0;
      sel_a_q   <= '0;
      sel_b_q   <= '0;
      csel_q    <= '0;
      oen_q     <= '0;
      lvl_q     <= '0;
      mode_q    <= '0;
      for (int n = 0; n < NUM_CH; n++) reload_q[n] <= '0;
    end else if (wr_en) begin
      if (hit(wr_addr, ADR_CTRL))  unit_en_q <= wr_data[0];
      if (hit(wr_addr, ADR_PRESC)) begin
        sel_a_q <= wr_data[SEL_W-1:0];
        sel_b_q <= wr_data[2*SEL_W-1:SEL_W];
      end
      if (hit(wr_addr, ADR_CSEL)) csel_q <= wr_data[NUM_CH-1:0];
      if (hit(wr_addr, ADR_OEN))  oen_q  <= wr_data[NUM_CH-1:0];
      if (hit(wr_addr, ADR_LVL))  lvl_q  <= wr_data[NUM_CH-1:0];
      if (hit(wr_addr, ADR_MODE)) mode_q <= wr_data[NUM_CH-1:0];
      for (int n = 0; n < NUM_CH; n++)
        if (hit(wr_addr, ADR_RELOAD + n)) reload_q[n] <= wr_data[CNT_W-1:0];
    end
  end

  always_comb begin
    rd_data = '0;
    if (hit(rd_addr, ADR_CTRL))   rd_data[0] = unit_en_q;
    if (hit(rd_addr, ADR_PRESC))  rd_data[2*SEL_W-1:0] = {sel_b_q, sel_a_q};
    if (hit(rd_addr, ADR_STATUS)) rd_data = {{PAD_CH{1'b0}}, run_vec};
    if (hit(rd_addr, ADR_OEN))    rd_data = {{PAD_CH{1'b0}}, oen_q};
    if (hit(rd_addr, ADR_OBUF))   rd_data = {{PAD_CH{1'b0}}, ch_out};
    if (hit(rd_addr, ADR_LVL))    rd_data = {{PAD_CH{1'b0}}, lvl_q};
    if (hit(rd_addr, ADR_MODE))   rd_data = {{PAD_CH{1'b0}}, mode_q};
    if (hit(rd_addr, ADR_CSEL))   rd_data = {{PAD_CH{1'b0}}, csel_q};
    for (int n = 0; n < NUM_CH; n++)
      if (hit(rd_addr, ADR_RELOAD + n)) rd_data = DATA_W'(reload_q[n]);
  end

  timer_prescaler presc_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (unit_en_q),
    .sel_a_i  (sel_a_q),
    .sel_b_i  (sel_b_q),
    .tick_a_o (tick_a),
    .tick_b_o (tick_b)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    timer_channel #(.CNT_W(CNT_W)) chan_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (csel_q[n] ? tick_b : tick_a),
      .start_i  (start_vec[n]),
      .stop_i   (stop_vec[n]),
      .reload_i (reload_q[n]),
      .run_o    (run_vec[n]),
      .ev_o     (ev_vec[n])
    );
  end

  timer_output_ctl #(.NUM_CH(NUM_CH)) outc_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_i      (ev_vec),
    .oen_i     (oen_q),
    .mode_i    (mode_q),
    .lvl_i     (lvl_q),
    .sw_we_i   (obuf_we),
    .sw_data_i (wr_data[NUM_CH-1:0]),
    .pin_o     (ch_out)
  );

  // status moves only on a trigger bit of 1
  assert_status_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start_vec == '0 && stop_vec == '0) |=> $stable(run_vec));

  // no event can come from a disabled unit
  assert_quiet_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !unit_en_q |-> ev_vec == '0);

endmodule

// File: tb/timer_unit_top_tb_top.sv
`timescale 1ns/1ps
module timer_unit_top_tb_top;

  localparam int NCH = 8;
  localparam logic [4:0] A_CTRL = 5'd0, A_PRESC = 5'd1, A_STATUS = 5'd2, A_START = 5'd3,
                         A_STOP = 5'd4, A_OEN = 5'd5, A_OBUF = 5'd6, A_LVL = 5'd7,
                         A_MODE = 5'd8, A_CSEL = 5'd9, A_REL = 5'd16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [4:0]  rd_addr = A_STATUS;
  logic [15:0] rd_data;
  logic [7:0]  ch_out;

  int    checks = 0;
  int    errors = 0;
  string tag = "R10";
  bit    cmp_on = 1'b0;

  always #2 clk = ~clk;

  timer_unit_top dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ch_out(ch_out)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      if (errors < 30) $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- bench model (tick-count formulation) ----------------
  logic        m_en;
  logic [3:0]  m_sa, m_sb;
  logic [7:0]  m_csel, m_oen, m_lvl, m_mode, m_run, m_buf;
  logic [15:0] m_rel [NCH];
  int          m_t   [NCH];
  logic [15:0] m_pc;

  function automatic bit tick_due(input logic [15:0] pc, input logic [3:0] s);
    int p = 1 << s;
    return (int'(pc) % p) == p - 1;
  endfunction

  always @(posedge clk) begin : model
    logic       ta, tb, tk;
    logic [7:0] ev, st, sp, nb;
    int         per;
    if (!rst_n) begin
      m_en <= 0; m_sa <= 0; m_sb <= 0; m_csel <= 0; m_oen <= 0; m_lvl <= 0;
      m_mode <= 0; m_run <= 0; m_buf <= 0; m_pc <= 0;
      for (int n = 0; n < NCH; n++) begin m_rel[n] <= 0; m_t[n] <= 0; end
    end else begin
      ta = m_en && tick_due(m_pc, m_sa);
      tb = m_en && tick_due(m_pc, m_sb);
      st = (wr_en && wr_addr == A_START) ? wr_data[7:0] : 8'h00;
      sp = (wr_en && wr_addr == A_STOP)  ? wr_data[7:0] : 8'h00;
      ev = 8'h00;
      for (int n = 0; n < NCH; n++) begin
        tk = m_csel[n] ? tb : ta;
        if (st[n]) begin m_t[n] <= 0; m_run[n] <= 1'b1; end
        else if (sp[n]) m_run[n] <= 1'b0;
        else if (m_run[n] && tk) begin
          per   = int'(m_rel[n]) + 1;
          ev[n] = (m_t[n] > 0) && (m_t[n] % per == 0);
          m_t[n] <= m_t[n] + 1;
        end
      end
      nb = m_buf;
      for (int n = 0; n < NCH; n++) begin
        if (!m_oen[n]) begin
          if (wr_en && wr_addr == A_OBUF) nb[n] = wr_data[n];
        end else if (!m_mode[n]) begin
          if (ev[n]) nb[n] = ~nb[n];
        end else if (n % 2 == 1) begin
          if (ev[n]) nb[n] = m_lvl[n];
          else if (ev[n-1]) nb[n] = ~m_lvl[n];
        end
      end
      m_buf <= nb;
      m_pc  <= m_en ? m_pc + 16'd1 : 16'd0;
      if (wr_en) begin
        case (wr_addr)
          A_CTRL:  m_en <= wr_data[0];
          A_PRESC: begin m_sa <= wr_data[3:0]; m_sb <= wr_data[7:4]; end
          A_CSEL:  m_csel <= wr_data[7:0];
          A_OEN:   m_oen  <= wr_data[7:0];
          A_LVL:   m_lvl  <= wr_data[7:0];
          A_MODE:  m_mode <= wr_data[7:0];
          default: ;
        endcase
        for (int n = 0; n < NCH; n++)
          if (wr_addr == A_REL + 5'(n)) m_rel[n] <= wr_data;
      end
    end
  end

  // per-cycle comparison with the model, away from the active edge
  always @(negedge clk) begin
    #1;
    if (cmp_on) begin
      check(tag, "pins vs model", {24'b0, ch_out}, {24'b0, m_buf});
      if (rd_addr == A_STATUS)
        check(tag, "status vs model", {16'b0, rd_data}, {24'b0, m_run});
    end
  end

  // ---------------- driver tasks ----------------
  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    rd_addr = a;
    #1 d = rd_data;
    @(negedge clk);
    rd_addr = A_STATUS;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #600000;
    errors++;
    $display("FAIL watchdog run not finished actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [15:0] d, s;
    logic        p, p5;
    int          gap;
    void'($urandom(32'd4711));

    idle(3);
    @(negedge clk) rst_n = 1'b1;

    // R10: reset values
    tag = "R10";
    check("R10", "pins after reset", {24'b0, ch_out}, 32'h0);
    rd(A_CTRL, d);   check("R10", "ctrl reset", {16'b0, d}, 32'h0);
    rd(A_PRESC, d);  check("R10", "presc reset", {16'b0, d}, 32'h0);
    rd(A_STATUS, d); check("R10", "status reset", {16'b0, d}, 32'h0);
    rd(A_OEN, d);    check("R10", "oen reset", {16'b0, d}, 32'h0);
    rd(A_MODE, d);   check("R10", "mode reset", {16'b0, d}, 32'h0);
    rd(A_REL + 5'd3, d); check("R10", "reload3 reset", {16'b0, d}, 32'h0);
    cmp_on = 1'b1;

    // R1: disabled unit does not count
    tag = "R1";
    wr(A_REL + 5'd0, 16'd2);
    wr(A_OEN, 16'h0003);
    wr(A_START, 16'h0001);
    idle(20);
    check("R1", "pin0 with unit off", {31'b0, ch_out[0]}, 32'h0);
    rd(A_STATUS, d); check("R3", "status after start", {16'b0, d}, 32'h1);
    wr(A_CTRL, 16'h0001);

    // R3 / R6: first event at R+2 ticks, then every R+1 (select 0: tick each cycle)
    tag = "R3";
    wr(A_REL + 5'd1, 16'd3);
    p = ch_out[1];
    wr(A_START, 16'h0002);
    idle(4); check("R3", "pin1 before first event", {31'b0, ch_out[1]}, {31'b0, p});
    idle(1); check("R3", "pin1 at first event", {31'b0, ch_out[1]}, {31'b0, ~p});
    idle(3); check("R6", "pin1 held between events", {31'b0, ch_out[1]}, {31'b0, ~p});
    idle(1); check("R6", "pin1 toggled again", {31'b0, ch_out[1]}, {31'b0, p});

    // R2: select A = 2 gives 4 cycles per tick, so 16 cycles between toggles
    tag = "R2";
    wr(A_PRESC, 16'h0002);
    p = ch_out[1];
    gap = 0;
    while (ch_out[1] == p && gap < 100) begin idle(1); gap++; end
    p = ch_out[1];
    gap = 0;
    while (ch_out[1] == p && gap < 100) begin idle(1); gap++; end
    check("R2", "toggle spacing at select 2", gap, 32'd16);
    rd(A_PRESC, d); check("R2", "presc readback", {16'b0, d}, 32'h2);

    // R4: stop halts channel 1
    tag = "R4";
    wr(A_STOP, 16'h0002);
    rd(A_STATUS, d); check("R4", "status bit1 cleared", {31'b0, d[1]}, 32'h0);
    p = ch_out[1];
    idle(40);
    check("R4", "pin1 frozen after stop", {31'b0, ch_out[1]}, {31'b0, p});

    // R5: triggers read 0, zero writes have no effect
    tag = "R5";
    rd(A_START, d); check("R5", "start reads zero", {16'b0, d}, 32'h0);
    rd(A_STOP, d);  check("R5", "stop reads zero", {16'b0, d}, 32'h0);
    rd(A_STATUS, s);
    wr(A_STOP, 16'h0000);
    wr(A_START, 16'h0000);
    rd(A_STATUS, d); check("R5", "status after zero triggers", {16'b0, d}, {16'b0, s});

    // R7: pair 4 (master, R=2) and 5 (slave, R=5), tick every cycle
    tag = "R7";
    wr(A_PRESC, 16'h0000);
    wr(A_STOP, 16'h00FF);
    wr(A_REL + 5'd4, 16'd2);
    wr(A_REL + 5'd5, 16'd5);
    wr(A_LVL, 16'h0000);
    wr(A_OBUF, 16'h0000);
    wr(A_MODE, 16'h0030);
    wr(A_OEN, 16'h0030);
    wr(A_START, 16'h0030);
    idle(3); check("R7", "pin5 before set", {31'b0, ch_out[5]}, 32'h0);
    idle(1); check("R7", "pin5 set by master", {31'b0, ch_out[5]}, 32'h1);
    idle(3); check("R7", "pin5 reset wins on coincidence", {31'b0, ch_out[5]}, 32'h0);
    idle(3); check("R7", "pin5 set again", {31'b0, ch_out[5]}, 32'h1);
    check("R7", "even master pin unchanged", {31'b0, ch_out[4]}, 32'h0);

    // R8: inversion applies only at set/reset moments
    tag = "R8";
    wr(A_LVL, 16'h0020);
    check("R8", "pin5 unchanged by level write", {31'b0, ch_out[5]}, 32'h1);
    idle(1); check("R8", "pin5 reset to inverted level", {31'b0, ch_out[5]}, 32'h1);
    idle(3); check("R8", "pin5 set to inverted level", {31'b0, ch_out[5]}, 32'h0);
    idle(3); check("R8", "pin5 reset again", {31'b0, ch_out[5]}, 32'h1);

    // R9: software ownership of the buffer
    tag = "R9";
    wr(A_STOP, 16'h0030);
    p5 = ch_out[5];
    wr(A_OBUF, {8'h00, 1'b0, 1'b1, ~p5, 5'b0});
    check("R9", "pin6 follows buffer write", {31'b0, ch_out[6]}, 32'h1);
    check("R9", "pin5 ignores buffer write", {31'b0, ch_out[5]}, {31'b0, p5});
    wr(A_REL + 5'd6, 16'd0);
    wr(A_START, 16'h0040);
    idle(10);
    check("R9", "pin6 unaffected by events", {31'b0, ch_out[6]}, 32'h1);

    // mixed random phase, checked against the model every cycle
    tag = "R6";
    for (int it = 0; it < 400; it++) begin
      int op = $urandom % 8;
      int ch = $urandom % NCH;
      case (op)
        0, 1: begin
          wr(A_STOP, 16'(1 << ch));
          wr(A_REL + 5'(ch), 16'($urandom % 7));
          wr(A_START, 16'(1 << ch));
        end
        2: wr(A_OEN,  16'($urandom % 256));
        3: wr(A_MODE, 16'($urandom % 256));
        4: wr(A_LVL,  16'($urandom % 256));
        5: wr(A_OBUF, 16'($urandom % 256));
        6: begin
          if ($urandom % 2 == 0) wr(A_PRESC, {8'h00, 4'($urandom % 4), 4'($urandom % 4)});
          else wr(A_CSEL, 16'($urandom % 256));
        end
        default: wr(A_CTRL, 16'(($urandom % 4) != 0));
      endcase
      idle($urandom % 12);
    end

    cmp_on = 1'b0;
    idle(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule